// File: doc/BRIEF.md
# Serial Control Register Slave with Burst Addressing

This block receives control settings for an audio processing chip over a two-wire serial bus and holds them in ten 8-bit registers. Bus lines are oversampled by the system clock, so the block never uses the serial clock as a clock. It accepts write transfers only. Each transfer carries a device address, then a register index byte, then any number of data bytes.

The top bit of the index byte picks the write pattern. When the bit is clear, every data byte lands in the one selected register. When it is set, the bytes land in successive registers. A 4-bit pointer steps through sixteen slots, and only slots 0 to 9 hold storage. The low bit of the device address comes from a strap pin, so two devices can share one bus. At reset each register loads its own default, and the four attenuator registers reset to a mute code.

Top module: `ctl_reg_slave`

## Requirements
- R1: After reset, registers 0..9 hold 0x3F, 0x7E, 0x00, 0x17, 0x77, 0x78, 0x78, 0x78, 0x78, 0x7E. The values mean: input attenuation at maximum; surround off, output fixed and effect code 1111; flat tone; natural-bass pins off; attenuators at coarse code 1111 (mute); voice canceller off, input code 11 and both record outputs fixed. `sdaPullDown` is 0 after reset.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP returns the slave to idle, and an idle slave neither acknowledges nor writes.
- R3: The first byte after a START is compared with 1000_00A0 (sent MSB first). Here A equals `addrStrap`, and the last bit, the write bit, must be 0. On a match the slave drives `sdaPullDown` high from the SCL fall after the 8th bit until the SCL fall after the 9th bit.
- R4: An address byte that mismatches, or that has its last bit set, gets no acknowledge. The rest of that transfer is then ignored until the next START or STOP, so no register changes.
- R5: The byte after a matched address is the index byte. Bit 7 is the burst flag, bits 6..4 are ignored and bits 3..0 give the register index. The index byte is acknowledged.
- R6: With the burst flag clear, every data byte up to the STOP is written to the same indexed register, and the last byte remains.
- R7: With the burst flag set, data byte k goes to index (start + k) mod 16. Bytes that land on indices 10 to 15 are acknowledged but discarded, and the pointer wraps from 15 to 0.
- R8: A register is written only once all 8 bits of a data byte have been received. A STOP part-way through a byte leaves every register unchanged.
- R9: A repeated START in the middle of a transfer restarts address matching, including after a rejected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset, loads defaults |
| scl | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (wired bus value) |
| addrStrap | input | 1 | Selects device address bit A |
| sdaPullDown | output | 1 | Open-drain enable: 1 pulls SDA low |
| regFlat | output | 80 | Register i at bits [8i+7:8i] |

## Verification
The assertions assume that SCL and SDA settle for several system clocks between changes. With that spacing the synchronized samples never see both lines move together, and START, STOP and data edges stay distinct. They also assume `addrStrap` holds steady during a transfer. The bench drives each bus phase as a quarter-period of six system clocks and changes SDA only while SCL is low, except for deliberate START and STOP. It changes the strap only while the bus is idle. It models the wired bus as the master's level ANDed with the inverse of the pull-down, so the acknowledge appears on the data line that the slave itself samples.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_REGS = 10;
  localparam int PTR_W = 4;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic shiftBit;
    logic loadSub;
    logic writeData;
  } dpCmd_t;

  function automatic logic [BYTE_W-1:0] regDefault(input int idx);
    case (idx)
      0: regDefault = 8'h3F;
      1: regDefault = 8'h7E;
      2: regDefault = 8'h00;
      3: regDefault = 8'h17;
      4: regDefault = 8'h77;
      5, 6, 7, 8: regDefault = 8'h78;
      9: regDefault = 8'h7E;
      default: regDefault = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctl_bus_ctrl.sv
module ctl_bus_ctrl
  import ctl_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd,
  output logic              sdaBit,
  output logic              ackOn
);
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0] bitCnt;
  logic inAck;
  logic evalNow, addrMatch;
  busState_t state;

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];
  assign sdaBit = sdaS;
  assign sclRise = sclS && !sclPrev;
  assign sclFall = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet = sclS && sclPrev && !sdaPrev && sdaS;
  assign addrMatch = (rxByte == {6'b100000, addrStrap, 1'b0});

  assign evalNow = sclFall && !inAck && (bitCnt == CNT_W'(BYTE_W)) && !startDet && !stopDet;

  always_comb begin
    cmd.shiftBit = sclRise && (bitCnt < CNT_W'(BYTE_W)) && (state != ST_IDLE)
                   && !startDet && !stopDet;
    cmd.loadSub = evalNow && (state == ST_SUB);
    cmd.writeData = evalNow && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state <= ST_IDLE;
      bitCnt <= '0;
      inAck <= 1'b0;
      ackOn <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (stopDet) begin
        state <= ST_IDLE;
        bitCnt <= '0;
        inAck <= 1'b0;
        ackOn <= 1'b0;
      end else if (startDet) begin
        state <= ST_ADDR;
        bitCnt <= '0;
        inAck <= 1'b0;
        ackOn <= 1'b0;
      end else if (cmd.shiftBit) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (sclFall && inAck) begin
        inAck <= 1'b0;
        ackOn <= 1'b0;
        bitCnt <= '0;
      end else if (evalNow) begin
        inAck <= 1'b1;
        case (state)
          ST_ADDR: begin
            ackOn <= addrMatch;
            state <= addrMatch ? ST_SUB : ST_SKIP;
          end
          ST_SUB: begin
            ackOn <= 1'b1;
            state <= ST_DATA;
          end
          ST_DATA: ackOn <= 1'b1;
          default: ackOn <= 1'b0;
        endcase
      end
    end
  end

  // R2: a STOP always lands the slave in idle with the line released
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !ackOn));
  // R3: the acknowledge level only moves at an SCL fall or a bus condition
  a_r3_ack_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (!sclFall && !startDet && !stopDet) |=> $stable(ackOn));
  // R4: a rejected transfer never acknowledges
  a_r4_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !ackOn);
  // R8: bit counter never passes a full byte
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/ctl_reg_dp.sv
module ctl_reg_dp
  import ctl_reg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCmd_t                     cmd,
  input  logic                       sdaBit,
  output logic [BYTE_W-1:0]          rxByte,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);
  logic [PTR_W-1:0] ptr;
  logic autoInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      ptr <= '0;
      autoInc <= 1'b0;
    end else begin
      if (cmd.shiftBit) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (cmd.loadSub) begin
        autoInc <= rxByte[BYTE_W-1];
        ptr <= rxByte[PTR_W-1:0];
      end else if (cmd.writeData && autoInc) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFlat[i*BYTE_W +: BYTE_W] <= regDefault(i);
      else if (cmd.writeData && ptr == PTR_W'(i)) regFlat[i*BYTE_W +: BYTE_W] <= rxByte;
    end
  end

  // R7: data aimed at an unbacked slot leaves storage untouched
  a_r7_discard_unused: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeData && ptr >= PTR_W'(NUM_REGS)) |=> $stable(regFlat));
  // R7: burst pointer advances by one per data byte, wrapping at 16
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeData && autoInc && !cmd.loadSub) |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R6: single-register mode keeps the pointer fixed
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.writeData && !autoInc) |=> $stable(ptr));
  // R8: storage changes only on a completed data byte
  a_r8_write_gated: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.writeData |=> $stable(regFlat));
endmodule

// File: rtl/ctl_reg_slave.sv
module ctl_reg_slave
  import ctl_reg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       scl,
  input  logic                       sdaIn,
  input  logic                       addrStrap,
  output logic                       sdaPullDown,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat
);
  dpCmd_t cmd;
  logic sdaBit;
  logic [BYTE_W-1:0] rxByte;

  ctl_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .rxByte(rxByte), .cmd(cmd), .sdaBit(sdaBit), .ackOn(sdaPullDown)
  );

  ctl_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaBit),
    .rxByte(rxByte), .regFlat(regFlat)
  );
endmodule

// File: tb/tb_ctl_reg_slave.sv
module tb_ctl_reg_slave;
  localparam int Q = 6;
  logic clk = 0, rstN = 0, scl = 1, sdaM = 1, strap = 0;
  logic sdaLine, pd;
  logic [79:0] regFlat;
  logic [7:0] model [10];
  logic [7:0] dBuf [16];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~pd;

  ctl_reg_slave dut (.clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaLine),
    .addrStrap(strap), .sdaPullDown(pd), .regFlat(regFlat));

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1; waitQ(); scl = 1; waitQ(); sdaM = 0; waitQ(); scl = 0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 0; waitQ(); scl = 1; waitQ(); sdaM = 1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(); scl = 1; waitQ(); waitQ(); scl = 0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1; waitQ(); scl = 1; waitQ(); acked = ~sdaLine; waitQ(); scl = 0; waitQ();
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < 10; i++) chk(req, regFlat[i*8 +: 8], model[i]);
  endtask

  // full write: address, index byte, n data bytes from dBuf, then STOP
  task automatic writeTxn(input logic [7:0] addr, input logic [7:0] sub, input int n, input string req);
    logic a;
    logic [3:0] p;
    busStart();
    sendByte(addr, a); chk({req, " addr ack (R3)"}, a, 1);
    sendByte(sub, a); chk({req, " index ack (R5)"}, a, 1);
    p = sub[3:0];
    for (int k = 0; k < n; k++) begin
      sendByte(dBuf[k], a); chk({req, " data ack"}, a, 1);
      if (p < 10) model[p] = dBuf[k];
      if (sub[7]) p = p + 1;
    end
    busStop();
    waitQ();
    checkRegs(req);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    model = '{8'h3F, 8'h7E, 8'h00, 8'h17, 8'h77, 8'h78, 8'h78, 8'h78, 8'h78, 8'h7E};
    repeat (4) @(negedge clk);
    rstN = 1;
    waitQ();
    checkRegs("R1 reset default");
    chk("R1 pull-down idle", pd, 0);

    // R3/R4: sweep every address byte with strap 0, only 0x80 acknowledged
    for (int v = 0; v < 256; v++) begin
      busStart();
      sendByte(8'(v), a);
      chk("R3/R4 address sweep", a, (v == 8'h80));
      busStop();
    end
    checkRegs("R4 sweep leaves regs");

    // R3: strap tied high moves the address to 0x82
    waitQ(); strap = 1; waitQ();
    busStart(); sendByte(8'h80, a); chk("R3 strap1 rejects 0x80", a, 0); busStop();
    dBuf[0] = 8'h11;
    writeTxn(8'h82, 8'h02, 1, "R3 strap1 write");
    waitQ(); strap = 0; waitQ();

    // R4: rejected address followed by index/data must not write
    foreach (dBuf[i]) dBuf[i] = 8'hA0 + 8'(i);
    busStart(); sendByte(8'h81, a); chk("R4 read bit nack", a, 0);
    sendByte(8'h01, a); chk("R4 ignored index", a, 0);
    sendByte(8'h55, a); chk("R4 ignored data", a, 0);
    busStop(); waitQ(); checkRegs("R4 no write after nack");

    // R6: single mode, three bytes to register 3, last one stays
    dBuf[0] = 8'h01; dBuf[1] = 8'h02; dBuf[2] = 8'h5C;
    writeTxn(8'h80, 8'h73, 3, "R6 single mode");

    // R6: single mode into an unbacked index is dropped
    dBuf[0] = 8'hEE;
    writeTxn(8'h80, 8'h0C, 2, "R7 unbacked single");

    // R7: burst starting at 8 crosses 10..15 and wraps to 0,1
    foreach (dBuf[i]) dBuf[i] = 8'hC0 + 8'(i * 3);
    writeTxn(8'h80, 8'hF8, 10, "R7 burst wrap");

    // R7: full burst over all 16 slots from 0
    foreach (dBuf[i]) dBuf[i] = 8'(i * 17 + 5);
    writeTxn(8'h80, 8'h80, 16, "R7 burst full loop");

    // R8: STOP after 4 data bits leaves register untouched
    busStart(); sendByte(8'h80, a); sendByte(8'h04, a);
    sendBits(8'h00, 4); busStop(); waitQ();
    checkRegs("R8 partial byte");

    // R9: repeated START mid-transfer restarts matching
    busStart(); sendByte(8'h80, a); sendByte(8'h05, a);
    busStart(); sendByte(8'h80, a); chk("R9 restart addr ack", a, 1);
    sendByte(8'h06, a); sendByte(8'h3C, a); model[6] = 8'h3C;
    busStop(); waitQ(); checkRegs("R9 repeated start");

    // R9: repeated START after a rejected address
    busStart(); sendByte(8'h90, a); chk("R9 reject first", a, 0);
    busStart(); sendByte(8'h80, a); chk("R9 accept after reject", a, 1);
    sendByte(8'h09, a); sendByte(8'h42, a); model[9] = 8'h42;
    busStop(); waitQ(); checkRegs("R9 after reject");

    // R2: after STOP, bytes without a START are ignored
    sendByte(8'h80, a); chk("R2 idle no ack", a, 0);
    sendByte(8'h00, a); sendByte(8'hFF, a);
    waitQ(); checkRegs("R2 idle no write");
    chk("R2 pull-down released", pd, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule